// File: doc/BRIEF.md
# Byte-Serial Rotating Check-Word Accumulator

This block folds one data byte into a running 16-bit check word per command. A caller presents the current check word on `seed_i`, a data word on `data_i` (only its low byte matters) and pulses `start_i` for one clock. The block mixes the byte into the seed, then spends eight clocks on eight update steps. It then pulses `done_o` for one clock while `result_o` carries the new check word. The caller uses that pulse as the write-enable for storing the word back.

Each update step rotates the word right by one position, so bit 0 moves into bit 15. If the new bit 15 is 1, the step then XORs in a fixed mask, octal 020001 (hex 0x2001). This rotate-then-conditional-XOR scheme is not a plain shift register with feedback on the carry-out. Fetching the word, framing several bytes and decoding commands are left to the caller.

The controller has three named states:
- IDLE: waits for a start.
- RUN: one update step per clock, with `busy_o` high.
- DONE: a one-cycle result window.

Its transitions are:
- IDLE→RUN on `start_i`.
- RUN→RUN while the step counter is below its last value.
- RUN→DONE on the last step.
- DONE→RUN on `start_i`, a back-to-back command.
- DONE→IDLE otherwise.

Top module: `crc_rot_unit`

## Requirements
- R1: On an accepted start, the working word is loaded with `seed_i` XOR the low 8 bits of `data_i`, zero-extended. Bits 15..8 of `data_i` have no effect on the result.
- R2: Exactly eight update steps are applied per command. Each step rotates the 16-bit word right by one, with old bit 0 becoming bit 15.
- R3: After each rotate, if bit 15 of the rotated word is 1, the word is XORed with 16'h2001. Otherwise it is left as rotated.
- R4: `busy_o` is high for exactly eight consecutive cycles, beginning in the cycle after the clock edge that accepts the start.
- R5: `done_o` is high for exactly one cycle, the cycle after `busy_o` falls. In that cycle `result_o` equals the updated check word, and `done_o` is the write-enable for it.
- R6: A start strobe while `busy_o` is high is ignored. It changes neither the result nor the timing of the command in progress.
- R7: A synchronous active-high `rst` clears `busy_o`, `done_o` and `result_o` to 0 on the next edge, including in the middle of a command.
- R8: A start presented during the `done_o` cycle is accepted, giving back-to-back commands with no idle cycle.
- R9: After `done_o`, and while no new start is accepted, `result_o` keeps the last result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle command strobe |
| data_i | input | 16 | Data word; only bits 7..0 are used |
| seed_i | input | 16 | Current check word |
| busy_o | output | 1 | High during the eight step cycles |
| done_o | output | 1 | One-cycle result-valid / write-enable pulse |
| result_o | output | 16 | Working / updated check word |

## Verification
The bench builds the block with its defaults: a 16-bit word, an 8-bit byte, eight steps and mask 16'h2001. These make the exact step count, the bit-15 feedback and the 0x2001 XOR pattern visible in every result. With these values, all-zero and all-ones seeds and bytes can be reached, as can a seed whose rotations hit the mask on every step. Also within reach are an upper data byte that must be ignored, strobes in the middle of a command and back-to-back commands in the done cycle.

// File: rtl/crc_rot_pkg.sv
package crc_rot_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } crc_state_e;

endpackage

// File: rtl/crc_rot_step.sv
module crc_rot_step #(
    parameter int          WORD_W = 16,
    parameter logic [15:0] MASK   = 16'h2001
) (
    input  logic [WORD_W-1:0] cur_i,
    output logic [WORD_W-1:0] nxt_o
);
    logic [WORD_W-1:0] rot;

    // rotate right by one: bit 0 wraps into the top bit
    assign rot = {cur_i[0], cur_i[WORD_W-1:1]};

    // apply the feedback mask bit by bit, gated by the new top bit
    for (genvar i = 0; i < WORD_W; i++) begin : g_bit
        if (i < 16) begin : g_m
            assign nxt_o[i] = rot[i] ^ (MASK[i] & rot[WORD_W-1]);
        end else begin : g_nm
            assign nxt_o[i] = rot[i];
        end
    end
endmodule

// File: rtl/crc_rot_ctrl.sv
module crc_rot_ctrl
    import crc_rot_pkg::*;
#(
    parameter int STEPS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic busy_o,
    output logic done_o
);
    localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

    crc_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // step counter
    always_ff @(posedge clk) begin
        if (rst)                   cnt_q <= '0;
        else if (load_o)           cnt_q <= '0;
        else if (state_q == ST_RUN) cnt_q <= cnt_q + 1'b1;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_RUN;
            ST_RUN:  if (cnt_q == LAST) state_d = ST_DONE;
            ST_DONE: state_d = start_i ? ST_RUN : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load_o = 1'b0;
        step_o = 1'b0;
        busy_o = 1'b0;
        done_o = 1'b0;
        unique case (state_q)
            ST_IDLE: load_o = start_i;
            ST_RUN: begin
                step_o = 1'b1;
                busy_o = 1'b1;
            end
            ST_DONE: begin
                done_o = 1'b1;
                load_o = start_i;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/crc_rot_acc.sv
module crc_rot_acc #(
    parameter int          WORD_W = 16,
    parameter int          BYTE_W = 8,
    parameter logic [15:0] MASK   = 16'h2001
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic              step_i,
    input  logic [WORD_W-1:0] seed_i,
    input  logic [WORD_W-1:0] data_i,
    output logic [WORD_W-1:0] acc_o
);
    localparam int PAD_W = WORD_W - BYTE_W;

    logic [WORD_W-1:0] acc_q, acc_step, init_val;

    assign init_val = seed_i ^ {{PAD_W{1'b0}}, data_i[BYTE_W-1:0]};

    crc_rot_step #(.WORD_W(WORD_W), .MASK(MASK)) u_step (
        .cur_i (acc_q),
        .nxt_o (acc_step)
    );

    always_ff @(posedge clk) begin
        if (rst)         acc_q <= '0;
        else if (load_i) acc_q <= init_val;
        else if (step_i) acc_q <= acc_step;
    end

    assign acc_o = acc_q;
endmodule

// File: rtl/crc_rot_unit.sv
module crc_rot_unit #(
    parameter int          WORD_W = 16,
    parameter int          BYTE_W = 8,
    parameter int          STEPS  = 8,
    parameter logic [15:0] MASK   = 16'o020001
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [WORD_W-1:0] data_i,
    input  logic [WORD_W-1:0] seed_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [WORD_W-1:0] result_o
);
    logic load, step;

    crc_rot_ctrl #(.STEPS(STEPS)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .load_o  (load),
        .step_o  (step),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    crc_rot_acc #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .MASK(MASK)) u_acc (
        .clk    (clk),
        .rst    (rst),
        .load_i (load),
        .step_i (step),
        .seed_i (seed_i),
        .data_i (data_i),
        .acc_o  (result_o)
    );
endmodule

// File: rtl/crc_rot_unit_chk.sv
module crc_rot_unit_chk #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [WORD_W-1:0] result_o
);
    // R5
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy_o && done_o));

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R5
    done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(busy_o));

    // R4
    start_to_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o);

    // R7
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!busy_o && !done_o && result_o == '0));

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i && !done_o) |=> $stable(result_o));
endmodule

bind crc_rot_unit crc_rot_unit_chk #(.WORD_W(WORD_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .result_o (result_o)
);

// File: tb/crc_rot_unit_bench.sv
`timescale 1ns/1ps
module crc_rot_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [15:0] data_i = '0;
    logic [15:0] seed_i = '0;
    logic        busy_o, done_o;
    logic [15:0] result_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    crc_rot_unit u_crc_rot_unit (
        .clk(clk), .rst(rst), .start_i(start_i), .data_i(data_i),
        .seed_i(seed_i), .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
    );

    function automatic logic [15:0] ref_crc(input logic [15:0] s, input logic [15:0] d);
        logic [15:0] t;
        t = s ^ {8'h00, d[7:0]};
        for (int k = 0; k < 8; k++) begin
            t = {t[0], t[15:1]};
            if (t[15]) t = t ^ 16'h2001;
        end
        return t;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge where done_o is seen.
    // poke_at > 0 pulses a junk start during that busy cycle (R6).
    task automatic run_op(input logic [15:0] s, input logic [15:0] d, input int poke_at,
                          output logic [15:0] res);
        int busy_cnt = 0;
        bit seen = 0;
        seed_i = s; data_i = d; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int c = 0; c < 20 && !seen; c++) begin
            if (busy_cnt == poke_at && poke_at > 0) begin
                start_i = 1'b0;
            end
            if (done_o) seen = 1;
            else begin
                if (busy_o) busy_cnt++;
                if (busy_cnt == poke_at && poke_at > 0) begin
                    seed_i = ~s; data_i = ~d; start_i = 1'b1;
                end
                @(negedge clk);
                start_i = 1'b0;
            end
        end
        check("R4 busy cycles", busy_cnt, 8);
        check("R5 done seen", seen, 1);
        res = result_o;
        check("R2/R3 result", result_o, ref_crc(s, d));
    endtask

    task automatic run_idle(input logic [15:0] s, input logic [15:0] d, input int poke_at);
        logic [15:0] r;
        run_op(s, d, poke_at, r);
        @(negedge clk);
        check("R5 done one cycle", done_o, 0);
        check("R9 result held", result_o, r);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] r1, r2;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R7 reset state
        check("R7 busy after reset", busy_o, 0);
        check("R7 done after reset", done_o, 0);
        check("R7 result after reset", result_o, 16'h0000);

        // directed corners: R2, R3
        run_idle(16'h0000, 16'h0000, 0);
        run_idle(16'hFFFF, 16'h00FF, 0);
        run_idle(16'hFFFF, 16'h0000, 0);
        run_idle(16'h0000, 16'h00FF, 0);
        run_idle(16'h0001, 16'h0000, 0);

        // R1 upper byte ignored
        run_op(16'h1357, 16'hAB12, 0, r1);
        @(negedge clk);
        run_op(16'h1357, 16'h0012, 0, r2);
        check("R1 upper byte ignored", r1, r2);
        @(negedge clk);

        // R6 start while busy ignored
        run_idle(16'hBEEF, 16'h0042, 3);
        run_idle(16'h1234, 16'h00A5, 8);

        // R8 back-to-back in done cycle
        run_op(16'h4321, 16'h0077, 0, r1);
        run_op(r1, 16'h0088, 0, r2);
        check("R8 chained result", r2, ref_crc(ref_crc(16'h4321, 16'h0077), 16'h0088));
        @(negedge clk);

        // random vectors
        for (int i = 0; i < 200; i++) begin
            logic [15:0] s, d;
            s = 16'($urandom);
            d = 16'($urandom);
            run_idle(s, d, (i % 5 == 0) ? 1 + (i % 8) : 0);
        end

        // R7 reset mid-command
        seed_i = 16'h5A5A; data_i = 16'h0033; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R7 busy mid reset", busy_o, 0);
        check("R7 done mid reset", done_o, 0);
        check("R7 result mid reset", result_o, 16'h0000);
        rst = 1'b0;
        @(negedge clk);
        check("R7 stays idle", busy_o, 0);

        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule